// File: doc/BRIEF.md
# Hint-Based Clock Gating Controller

This block produces clock-enable signals for two groups of downstream units. The gating itself happens elsewhere, at the clock-gate cells or at the enable pins of the units. Always-on peripherals have one enable bit each in a software register. Every peripheral bit is set after reset.

Transactional units are driven by a software hint register together with an idle input from each unit. Clearing a hint does not stop a busy unit. Its clock keeps running until the unit reports idle. Software can read the real gating state back through a read-only status register.

A power-manager clock enable takes precedence over both software registers. A 4-bit scan-mode input in its On pattern forces every enable high. A separate jitter-enable register drives an output pin directly. Software reaches the registers through a simple write/read strobe port.

Top module: `clk_gate_ctrl`

## Requirements
- R1: With scan mode off and the power clock enable high, each peripheral enable equals its bit in the peripheral enable register (address 0, bits [3:0], bit i for peripheral i) from the cycle after the write.
- R2: After reset all peripheral enable bits are 1, so every peripheral enable output is high.
- R3: With scan mode off and the power clock enable high, a transactional enable is high whenever its bit in the hint register (address 1, bits [3:0]) is 1.
- R4: A transactional unit whose hint bit is 0 and whose idle input is 0 (busy) keeps its enable high while the power clock enable is high.
- R5: A transactional unit whose hint bit is 0 and whose idle input is 1 has its enable low when scan mode is off. Hint bits reset to all ones.
- R6: Scan mode counts as On only for the pattern 4'b0101, and On forces every peripheral and transactional enable high. Any other pattern leaves gating to the registers and inputs.
- R7: The status register (address 2, bits [3:0]) reads 1 exactly for the transactional units whose enable is high. Writes to address 2 have no effect.
- R8: The jitter-enable output equals bit 0 of the last value written to address 3, starting the cycle after the write. It is 0 after reset, and it reads back at address 3.
- R9: With scan mode off, a low power clock enable drives every peripheral and transactional enable low.
- R10: Read data is combinational while the read strobe is high, is zero-extended above the field, and is 0 while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pwr_clk_en_i | input | 1 | Power-manager clock enable |
| scanmode_i | input | 4 | Multi-bit scan mode, On = 4'b0101 |
| idle_i | input | 4 | Per-unit idle flags for transactional units |
| peri_clk_en_o | output | 4 | Peripheral clock enables |
| trans_clk_en_o | output | 4 | Transactional clock enables |
| jitter_en_o | output | 1 | Jitter enable |

## Verification
The peripheral register is written with a mixed pattern and toggled against the power enable, which separates register-driven gating from power-driven gating. The transactional units are driven with hints cleared while all units are busy, then with a split idle pattern, then with all units idle. This shows that busy units hold their clock while idle ones stop, and that status matches the hint once every unit is idle. Scan mode is applied both in its On pattern and in a pattern one bit away from it, which confirms that only the exact encoding forces the clocks on. The jitter register is written with both values.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  localparam int unsigned SCAN_W = 4;
  localparam logic [SCAN_W-1:0] SCAN_ON = 4'b0101;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERI = 2'd0,
    REG_HINT = 2'd1,
    REG_STAT = 2'd2,
    REG_JIT  = 2'd3
  } reg_addr_e;

  function automatic logic scan_is_on(logic [SCAN_W-1:0] s);
    return s == SCAN_ON;
  endfunction
endpackage

// File: rtl/clk_gate_regs.sv
module clk_gate_regs
  import clk_gate_pkg::*;
#(
  parameter int unsigned NP = 4,
  parameter int unsigned NT = 4,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NT-1:0]     status_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NP-1:0]     peri_q_o,
  output logic [NT-1:0]     hint_q_o,
  output logic              jit_q_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peri_q_o <= '1;
      hint_q_o <= '1;
      jit_q_o  <= 1'b0;
    end else if (wr_en_i) begin
      case (addr)
        REG_PERI: peri_q_o <= wdata_i[NP-1:0];
        REG_HINT: hint_q_o <= wdata_i[NT-1:0];
        REG_JIT:  jit_q_o  <= wdata_i[0];
        default:  ;  // status is read-only
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr)
        REG_PERI: rdata_o[NP-1:0] = peri_q_o;
        REG_HINT: rdata_o[NT-1:0] = hint_q_o;
        REG_STAT: rdata_o[NT-1:0] = status_i;
        REG_JIT:  rdata_o[0]      = jit_q_o;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/clk_gate_peri.sv
module clk_gate_peri #(
  parameter int unsigned NP = 4
) (
  input  logic          scan_on_i,
  input  logic          pwr_en_i,
  input  logic [NP-1:0] en_q_i,
  output logic [NP-1:0] en_o
);
  for (genvar i = 0; i < NP; i++) begin : g_unit
    assign en_o[i] = scan_on_i | (pwr_en_i & en_q_i[i]);
  end
endmodule

// File: rtl/clk_gate_trans.sv
module clk_gate_trans #(
  parameter int unsigned NT = 4
) (
  input  logic          scan_on_i,
  input  logic          pwr_en_i,
  input  logic [NT-1:0] hint_q_i,
  input  logic [NT-1:0] idle_i,
  output logic [NT-1:0] en_o
);
  for (genvar i = 0; i < NT; i++) begin : g_unit
    logic want;
    // a busy unit holds its clock even after its hint is cleared
    assign want    = hint_q_i[i] | ~idle_i[i];
    assign en_o[i] = scan_on_i | (pwr_en_i & want);
  end
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter int unsigned NP = 4,
  parameter int unsigned NT = 4,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              pwr_clk_en_i,
  input  logic [SCAN_W-1:0] scanmode_i,
  input  logic [NT-1:0]     idle_i,
  output logic [NP-1:0]     peri_clk_en_o,
  output logic [NT-1:0]     trans_clk_en_o,
  output logic              jitter_en_o
);
  logic          scan_on;
  logic [NP-1:0] peri_q;
  logic [NT-1:0] hint_q;

  assign scan_on = scan_is_on(scanmode_i);

  clk_gate_regs #(.NP(NP), .NT(NT), .DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (trans_clk_en_o),
    .rdata_o  (rdata_o),
    .peri_q_o (peri_q),
    .hint_q_o (hint_q),
    .jit_q_o  (jitter_en_o)
  );

  clk_gate_peri #(.NP(NP)) u_peri (
    .scan_on_i (scan_on),
    .pwr_en_i  (pwr_clk_en_i),
    .en_q_i    (peri_q),
    .en_o      (peri_clk_en_o)
  );

  clk_gate_trans #(.NT(NT)) u_trans (
    .scan_on_i (scan_on),
    .pwr_en_i  (pwr_clk_en_i),
    .hint_q_i  (hint_q),
    .idle_i    (idle_i),
    .en_o      (trans_clk_en_o)
  );
endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk
  import clk_gate_pkg::*;
#(
  parameter int unsigned NP = 4,
  parameter int unsigned NT = 4,
  parameter int unsigned DW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              pwr_clk_en_i,
  input logic [SCAN_W-1:0] scanmode_i,
  input logic [NT-1:0]     idle_i,
  input logic [NP-1:0]     peri_clk_en_o,
  input logic [NT-1:0]     trans_clk_en_o,
  input logic              jitter_en_o,
  input logic [NT-1:0]     hint_q
);
  logic on;
  assign on = (scanmode_i == SCAN_ON);

  assert_peri_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && $past(addr_i) == 2'd0 && !on && pwr_clk_en_i)
      |-> peri_clk_en_o == $past(wdata_i[NP-1:0]));

  assert_busy_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_clk_en_i) |-> ((trans_clk_en_o & ~idle_i) == ~idle_i));

  assert_idle_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on) |-> ((trans_clk_en_o & idle_i & ~hint_q) == '0));

  assert_scan_forces_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on |-> (&peri_clk_en_o && &trans_clk_en_o));

  assert_status_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 2'd2) |-> rdata_o[NT-1:0] == trans_clk_en_o);

  assert_jitter_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && $past(addr_i) == 2'd3) |-> jitter_en_o == $past(wdata_i[0]));

  assert_pwr_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on && !pwr_clk_en_i) |-> (peri_clk_en_o == '0 && trans_clk_en_o == '0));

  assert_rd_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i) |-> rdata_o == '0);
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(.NP(NP), .NT(NT), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .rd_en_i        (rd_en_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .rdata_o        (rdata_o),
  .pwr_clk_en_i   (pwr_clk_en_i),
  .scanmode_i     (scanmode_i),
  .idle_i         (idle_i),
  .peri_clk_en_o  (peri_clk_en_o),
  .trans_clk_en_o (trans_clk_en_o),
  .jitter_en_o    (jitter_en_o),
  .hint_q         (hint_q)
);

// File: tb/clk_gate_ctrl_test.sv
`timescale 1ns/1ps
module clk_gate_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       pwr_clk_en_i = 1'b1;
  logic [3:0] scanmode_i = 4'b1010;
  logic [3:0] idle_i = 4'b0000;
  logic [3:0] peri_clk_en_o;
  logic [3:0] trans_clk_en_o;
  logic       jitter_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;  // 0 peri, 1 trans, 2 rdata, 3 jitter
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];
  event  check_ev;

  always #4 clk_i = ~clk_i;

  clk_gate_ctrl uut (.*);

  // monitor
  initial forever begin
    @(check_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {4'b0, peri_clk_en_o};
        1: act = {4'b0, trans_clk_en_o};
        2: act = rdata_o;
        default: act = {7'b0, jitter_en_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic chk(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    ->check_ev;
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string req);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    #1;
    chk(2, exp, req);
    rd_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(0, 8'h0F, "R2 peri reset");
    chk(1, 8'h0F, "R5 hint reset");
    chk(3, 8'h00, "R8 jitter reset");
    chk(2, 8'h00, "R10 no read strobe");
    rd_chk(2'd1, 8'h0F, "R5 hint readback");

    wr(2'd0, 8'hF5);
    chk(0, 8'h05, "R1 peri write");
    rd_chk(2'd0, 8'h05, "R10 peri readback zero-extended");

    pwr_clk_en_i = 1'b0; #1;
    chk(0, 8'h00, "R9 pwr off peri");
    chk(1, 8'h00, "R9 pwr off trans");
    pwr_clk_en_i = 1'b1; #1;

    wr(2'd1, 8'h00);
    chk(1, 8'h0F, "R4 busy holds");
    rd_chk(2'd2, 8'h0F, "R7 status busy");

    idle_i = 4'b0011; #1;
    chk(1, 8'h0C, "R5 idle stops, R4 busy holds");
    rd_chk(2'd2, 8'h0C, "R7 status split");

    idle_i = 4'b1111; #1;
    chk(1, 8'h00, "R5 all idle");
    wr(2'd1, 8'h0A);
    chk(1, 8'h0A, "R3 hint enables");
    rd_chk(2'd2, 8'h0A, "R7 status equals hint");

    wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'h0A, "R7 status write ignored");
    chk(1, 8'h0A, "R7 trans unchanged");

    scanmode_i = 4'b0101; #1;
    chk(0, 8'h0F, "R6 scan on peri");
    chk(1, 8'h0F, "R6 scan on trans");
    scanmode_i = 4'b0100; #1;
    chk(0, 8'h05, "R6 near pattern peri");
    chk(1, 8'h0A, "R6 near pattern trans");
    scanmode_i = 4'b1010;

    wr(2'd3, 8'hFF);
    chk(3, 8'h01, "R8 jitter on");
    rd_chk(2'd3, 8'h01, "R8 jitter readback");
    wr(2'd3, 8'h00);
    chk(3, 8'h00, "R8 jitter off");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule